// File: doc/BRIEF.md
# Receive Condition Detect Register with Interrupt

This block gathers the one-bit outputs of a receiver's analog detectors (carrier present, answer tone, call-progress tone and long loop) into a read-only status byte. It also derives a fifth condition of its own: an unscrambled-mark flag. This flag is declared once the raw receive data, taken ahead of the descrambler, has stayed high without a break for a programmable time. The default time is 165.5 ms at the configured clock frequency.

Any change in a monitored status bit raises a level interrupt toward the control processor, with one exception: a change in the long-loop bit alone raises nothing. The interrupt stays asserted until the processor signals a read of the detect register with a one-cycle read strobe. A global enable input masks interrupts completely. Software has no way to write the status byte; it moves only when the monitored conditions move.

Top module: `detect_irq_reg`

## Requirements
- R1: While reset is asserted and after its release, before any clock edge, `status_o` is 0x00 and `irq_o` is 0.
- R2: At each rising clock edge, `status_o` captures the condition inputs. Bit 0 is carrier, bit 1 is answer tone, bit 2 is call-progress tone and bit 3 is long loop, taken from `cond_i[0..3]` in that order. Bits 7..5 are always 0.
- R3: Status bit 4 (unscrambled mark) becomes 1 at the edge that samples the MARK_CYCLES-th consecutive high `rx_raw_i`. MARK_CYCLES is CLK_HZ × MARK_TENTHS_MS / 10000. After MARK_CYCLES−1 consecutive high samples, bit 4 is still 0.
- R4: A low `rx_raw_i` sample clears bit 4 at that same edge and restarts the count, so a full MARK_CYCLES of high samples is needed again.
- R5: With `int_en_i` high, a change in any of status bits 0, 1, 2 or 4 sets `irq_o` at the same edge at which the status byte changes.
- R6: A change confined to status bit 3 (long loop) does not set `irq_o`.
- R7: Once set, `irq_o` stays 1 until an edge samples `rd_stb_i` high, and that edge clears it. If an interrupting change is sampled at the same edge, `irq_o` stays 1.
- R8: While `int_en_i` is low, `irq_o` is 0 from the next edge on. Changes sampled while it is low are discarded and do not appear when it is raised again.
- R9: `rd_stb_i` has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 4 | Raw detector flags: carrier, answer tone, call-progress, long loop |
| rx_raw_i | input | 1 | Receive data ahead of the descrambler |
| int_en_i | input | 1 | Global interrupt enable |
| rd_stb_i | input | 1 | One-cycle pulse marking a read of the detect register |
| status_o | output | 8 | Detect status byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps every ordered pair of the sixteen condition vectors. Each step clears the interrupt between the two vectors, so the check tells apart a change that touches an interrupting bit from one that touches only the long-loop bit. The mark timer is driven with high runs of exactly MARK_CYCLES−1 and MARK_CYCLES samples, which pins the terminal count to a single cycle. A run broken one sample short of the limit shows whether the count restarts from zero or merely pauses. Read strobes that coincide with changes, and condition changes made while interrupts are disabled, separate set-over-clear priority and discard-while-masked from the simpler alternatives.

// File: rtl/detect_pkg.sv
package detect_pkg;
    localparam int COND_W      = 4;
    localparam int DET_W       = 5;
    localparam int DET_CARRIER = 0;
    localparam int DET_ANSWER  = 1;
    localparam int DET_CPT     = 2;
    localparam int DET_LOOP    = 3;
    localparam int DET_MARK    = 4;
    // bits whose change requests an interrupt (long loop excluded)
    localparam logic [DET_W-1:0] IRQ_MASK = 5'b10111;
endpackage

// File: rtl/mark_timer.sv
module mark_timer #(
    parameter int unsigned CLK_HZ         = 50_000_000,
    parameter int unsigned MARK_TENTHS_MS = 1655
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic hit_o
);
    localparam longint unsigned MARK_CYCLES =
        (longint'(CLK_HZ) * longint'(MARK_TENTHS_MS)) / 64'd10000;
    localparam int CNT_W = (MARK_CYCLES > 2) ? $clog2(MARK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MARK_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tm_t;

    tm_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        hit_o = rx_i && (s_q.cnt == LIMIT);
        if (!rx_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != LIMIT) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LIMIT);
    p_climb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_i && s_q.cnt != LIMIT) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_i |=> (s_q.cnt == '0));
endmodule

// File: rtl/det_status.sv
module det_status
    import detect_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COND_W-1:0] cond_i,
    input  logic              mark_hit_i,
    output logic [DET_W-1:0]  det_o,
    output logic              evt_o
);
    typedef struct packed {
        logic [DET_W-1:0] det;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.det = {mark_hit_i, cond_i};
        evt_o   = |((s_d.det ^ s_q.det) & IRQ_MASK);
    end

    assign det_o = s_q.det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_q.det[COND_W-1:0] == $past(cond_i)));
    p_mark_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mark_hit_i |=> !s_q.det[DET_MARK]);
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rd_i,
    input  logic evt_i,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } ir_t;

    ir_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = en_i && ((s_q.pend && !rd_i) || evt_i);
    end

    assign irq_o = s_q.pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && evt_i) |=> irq_o);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && en_i && !rd_i) |=> irq_o);
    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o);
endmodule

// File: rtl/detect_irq_reg.sv
module detect_irq_reg
    import detect_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 50_000_000,
    parameter int unsigned MARK_TENTHS_MS = 1655
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  cond_i,
    input  logic        rx_raw_i,
    input  logic        int_en_i,
    input  logic        rd_stb_i,
    output logic [7:0]  status_o,
    output logic        irq_o
);
    logic             mark_hit;
    logic [DET_W-1:0] det;
    logic             evt;

    mark_timer #(
        .CLK_HZ        (CLK_HZ),
        .MARK_TENTHS_MS(MARK_TENTHS_MS)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .rx_i (rx_raw_i),
        .hit_o(mark_hit)
    );

    det_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .mark_hit_i(mark_hit),
        .det_o     (det),
        .evt_o     (evt)
    );

    irq_latch u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .en_i (int_en_i),
        .rd_i (rd_stb_i),
        .evt_i(evt),
        .irq_o(irq_o)
    );

    assign status_o = {{(8-DET_W){1'b0}}, det};

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:DET_W] == '0);
    p_loop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(irq_o) && ((status_o ^ $past(status_o)) == 8'h08)) |-> !irq_o);
endmodule

// File: tb/detect_irq_reg_test.sv
module detect_irq_reg_test;
    // scaled configuration: 20 kHz nominal clock keeps the mark window short
    localparam int unsigned CLK_HZ = 20000;
    localparam int unsigned TENTHS = 1655;
    localparam int MARK = int'((CLK_HZ * TENTHS) / 10000);   // 3310

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond = 4'h0;
    logic       rx = 1'b0;
    logic       en = 1'b1;
    logic       rd = 1'b0;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    detect_irq_reg #(.CLK_HZ(CLK_HZ), .MARK_TENTHS_MS(TENTHS)) uut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .rx_raw_i(rx),
        .int_en_i(en), .rd_stb_i(rd), .status_o(status), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at the falling edge, then move past the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_and_step(input logic [3:0] c, input logic r, input logic x);
        @(negedge clk);
        cond = c; rd = r; rx = x;
        step();
    endtask

    initial begin
        cond = 4'hF;
        rx   = 1'b1;
        #35;
        chk("R1 status in reset", 32'(status), 32'h00);
        chk("R1 irq in reset", 32'(irq), 32'h0);
        @(negedge clk);
        cond = 4'h0; rx = 1'b0;
        rst_n = 1'b1;
        step();
        chk("R1 status after reset", 32'(status), 32'h00);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2/R5/R6 sweep over every ordered pair of condition vectors
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                drive_and_step(4'(a), 1'b0, 1'b0);
                drive_and_step(4'(a), 1'b1, 1'b0);
                chk("R7 cleared by read", 32'(irq), 32'h0);
                drive_and_step(4'(b), 1'b0, 1'b0);
                chk("R2 status follows cond", 32'(status), 32'(b));
                chk("R5/R6 irq on change", 32'(irq),
                    32'(((a ^ b) & 4'b0111) != 0));
            end
        end

        // R7 hold without read, and set-over-clear
        drive_and_step(4'h0, 1'b1, 1'b0);
        drive_and_step(4'h1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) drive_and_step(4'h1, 1'b0, 1'b0);
        chk("R7 irq holds", 32'(irq), 32'h1);
        drive_and_step(4'h3, 1'b1, 1'b0);
        chk("R7 change beats read", 32'(irq), 32'h1);
        drive_and_step(4'h3, 1'b1, 1'b0);
        chk("R7 read clears", 32'(irq), 32'h0);

        // R9 read strobes leave status alone
        for (int i = 0; i < 4; i++) drive_and_step(4'h3, 1'b1, 1'b0);
        chk("R9 status untouched by read", 32'(status), 32'h03);

        // R8 masking
        drive_and_step(4'h3, 1'b0, 1'b0);
        @(negedge clk); en = 1'b0;
        drive_and_step(4'h7, 1'b0, 1'b0);
        chk("R8 irq low while disabled", 32'(irq), 32'h0);
        chk("R8 status still updates", 32'(status), 32'h07);
        drive_and_step(4'h2, 1'b0, 1'b0);
        @(negedge clk); en = 1'b1;
        step();
        chk("R8 masked change discarded", 32'(irq), 32'h0);
        drive_and_step(4'h6, 1'b0, 1'b0);
        chk("R8 irq after re-enable", 32'(irq), 32'h1);
        @(negedge clk); en = 1'b0;
        step();
        chk("R8 pending irq dropped", 32'(irq), 32'h0);
        @(negedge clk); en = 1'b1;
        drive_and_step(4'h0, 1'b1, 1'b0);
        drive_and_step(4'h0, 1'b1, 1'b0);

        // R3 terminal count
        for (int i = 0; i < MARK - 1; i++) drive_and_step(4'h0, 1'b0, 1'b1);
        chk("R3 mark not yet after MARK-1", 32'(status), 32'h00);
        chk("R3 no irq before mark", 32'(irq), 32'h0);
        drive_and_step(4'h0, 1'b0, 1'b1);
        chk("R3 mark set at MARK", 32'(status), 32'h10);
        chk("R5 irq on mark", 32'(irq), 32'h1);
        drive_and_step(4'h0, 1'b1, 1'b1);
        drive_and_step(4'h0, 1'b0, 1'b1);
        chk("R3 mark stays while high", 32'(status), 32'h10);

        // R4 low sample clears at once and restarts
        drive_and_step(4'h0, 1'b0, 1'b0);
        chk("R4 mark cleared by low", 32'(status), 32'h00);
        chk("R5 irq on mark drop", 32'(irq), 32'h1);
        drive_and_step(4'h0, 1'b1, 1'b0);
        for (int i = 0; i < MARK - 2; i++) drive_and_step(4'h0, 1'b0, 1'b1);
        drive_and_step(4'h0, 1'b0, 1'b0);
        for (int i = 0; i < MARK - 1; i++) drive_and_step(4'h0, 1'b0, 1'b1);
        chk("R4 count restarted from zero", 32'(status), 32'h00);
        drive_and_step(4'h0, 1'b0, 1'b1);
        chk("R4 mark after full new run", 32'(status), 32'h10);

        // R6 long loop with mark held
        drive_and_step(4'h0, 1'b1, 1'b1);
        drive_and_step(4'h8, 1'b0, 1'b1);
        chk("R6 loop change no irq", 32'(irq), 32'h0);
        chk("R2 loop bit position", 32'(status), 32'h18);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule